// File: doc/BRIEF.md
# Branch Trace Target Byte Emitter

This block formats debug trace records onto a byte-wide stream with a valid/ready handshake. When the core reports a taken branch, the block sends a chosen number of low-order bytes of the 32-bit branch target. A 2-bit setting selects that number. When ownership tracing is switched on, the block also sends a one-byte record that carries the current address-space identifier (ASID). Three events trigger that record: entry into user mode, a control-register write that loads the ASID, and a debug command that synchronises the program counter.

Branch bytes always take priority over an ASID record. An ASID event that arrives during a branch record waits in a one-entry holding register. While any record is still on the output, the block raises a busy flag. A taken branch seen while busy is dropped, and a saturating overflow counter counts it. A sideband bit on the stream tells ASID bytes apart from target-address bytes.

Top module: `trc_emitter`

## Requirements
- R1: While reset is high and in the cycle after it, `out_valid` and `busy` are 0 and `ovf_count` is 0.
- R2: A taken branch with byte-count code 2'b00 produces no output byte.
- R3: For byte-count codes 2'b01, 2'b10 and 2'b11, an accepted taken branch produces 2, 3 and 4 bytes of the target address, in that order by code. Bytes are sent as bits [7:0] first, then [15:8], and so on, one byte per handshake, each with `out_asid`=0. The first byte is valid in the cycle after the strobe.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_asid` hold their values.
- R5: With `own_en`=1, a pulse on `ev_user` produces a one-byte record equal to `asid` with `out_asid`=1.
- R6: With `own_en`=1, a pulse on `ev_asid_load` produces the same ASID record.
- R7: With `own_en`=1, a pulse on `ev_sync_pc` produces the same ASID record.
- R8: With `own_en`=0, none of the three events produces output.
- R9: If a branch and an ASID event arrive in the same cycle, all target bytes are sent first, then the ASID byte.
- R10: `busy` equals `out_valid`. A taken branch with a nonzero code that arrives while `busy` is 1 produces no bytes and adds 1 to `ovf_count`, which saturates at all ones. A code of 2'b00 while busy does not count.
- R11: An ASID event is dropped when the holding register is full and is not drained in that cycle. An event in the cycle the held byte is accepted loads the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bytes | input | 2 | Target byte-count code |
| own_en | input | 1 | Ownership trace enable |
| br_taken | input | 1 | Taken-branch strobe |
| br_target | input | ADDR_W | Branch target address |
| ev_user | input | 1 | User-mode entry strobe |
| ev_asid_load | input | 1 | ASID register load strobe |
| ev_sync_pc | input | 1 | Sync-PC command strobe |
| asid | input | ASID_W | Current address-space identifier |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Output byte valid |
| out_data | output | BYTE_W | Output byte |
| out_asid | output | 1 | 1 when the byte is an ASID record |
| busy | output | 1 | A record is in flight |
| ovf_count | output | OVF_W | Dropped-branch count, saturating |

## Verification
A wrong remaining-byte count in the branch sequencer shows at the ports as a record that is one byte short or one byte long. The first handshake after the expected last byte exposes it. A wrong shift order puts the wrong byte on `out_data` at the first handshake. The first sampled byte after the strobe exposes that. A holding-register fault either loses the ASID byte or repeats it. Either one is visible in the cycle after the branch record completes. Counter faults are visible in the cycle after a dropped strobe.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // Number of target bytes for a byte-count code.
  function automatic logic [2:0] bytes_for_code(input logic [1:0] code);
    case (code)
      2'b00:   bytes_for_code = 3'd0;
      2'b01:   bytes_for_code = 3'd2;
      2'b10:   bytes_for_code = 3'd3;
      default: bytes_for_code = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/trc_branch_seq.sv
module trc_branch_seq #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [1:0]        code,
  input  logic [ADDR_W-1:0] target,
  input  logic              advance,
  output logic              active,
  output logic [BYTE_W-1:0] cur_byte
);
  localparam int LANES = ADDR_W / BYTE_W;
  localparam int CNT_W = $clog2(LANES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (load) begin
      cnt_q   <= CNT_W'(trc_pkg::bytes_for_code(code));
      shift_q <= target;
    end else if (advance && cnt_q != '0) begin
      cnt_q   <= cnt_q - CNT_W'(1);
      shift_q <= shift_q >> BYTE_W;
    end
  end

  assign active   = (cnt_q != '0);
  assign cur_byte = shift_q[BYTE_W-1:0];
endmodule

// File: rtl/trc_asid_hold.sv
module trc_asid_hold #(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ASID_W-1:0] value,
  input  logic              drain,
  output logic              pending,
  output logic [ASID_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      held    <= '0;
    end else if (capture) begin
      pending <= 1'b1;
      held    <= value;
    end else if (drain) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/trc_ovf_cnt.sv
module trc_ovf_cnt #(
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [OVF_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != '1)
      count <= count + OVF_W'(1);
  end
endmodule

// File: rtl/trc_emitter.sv
module trc_emitter #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8,
  parameter int ASID_W = 8,
  parameter int OVF_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_bytes,
  input  logic              own_en,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              ev_user,
  input  logic              ev_asid_load,
  input  logic              ev_sync_pc,
  input  logic [ASID_W-1:0] asid,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_asid,
  output logic              busy,
  output logic [OVF_W-1:0]  ovf_count
);
  logic              br_active;
  logic [BYTE_W-1:0] br_byte;
  logic              as_pending;
  logic [ASID_W-1:0] as_held;
  logic              fire, asid_evt, as_capture, br_load, ovf_inc;

  assign fire       = out_valid & out_ready;
  assign asid_evt   = own_en & (ev_user | ev_asid_load | ev_sync_pc);
  assign as_capture = asid_evt & (~as_pending | (fire & ~br_active));
  assign br_load    = br_taken & ~busy & (cfg_bytes != 2'b00);
  assign ovf_inc    = br_taken & busy & (cfg_bytes != 2'b00);

  trc_branch_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) br_i (
    .clk(clk), .rst(rst), .load(br_load), .code(cfg_bytes),
    .target(br_target), .advance(fire), .active(br_active), .cur_byte(br_byte)
  );

  trc_asid_hold #(.ASID_W(ASID_W)) hold_i (
    .clk(clk), .rst(rst), .capture(as_capture), .value(asid),
    .drain(fire & ~br_active), .pending(as_pending), .held(as_held)
  );

  trc_ovf_cnt #(.OVF_W(OVF_W)) ovf_i (
    .clk(clk), .rst(rst), .inc(ovf_inc), .count(ovf_count)
  );

  assign out_valid = br_active | as_pending;
  assign out_asid  = ~br_active & as_pending;
  assign out_data  = br_active ? br_byte : BYTE_W'(as_held);
  assign busy      = out_valid;
endmodule

// File: rtl/trc_emitter_chk.sv
module trc_emitter_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8,
  parameter int OVF_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        cfg_bytes,
  input logic              own_en,
  input logic              br_taken,
  input logic [ADDR_W-1:0] br_target,
  input logic              ev_user,
  input logic              ev_asid_load,
  input logic              ev_sync_pc,
  input logic              out_ready,
  input logic              out_valid,
  input logic [BYTE_W-1:0] out_data,
  input logic              out_asid,
  input logic              busy,
  input logic [OVF_W-1:0]  ovf_count
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !out_valid && !busy && ovf_count == '0); // R1

  AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (rst)
    !busy && br_taken && cfg_bytes == 2'b00 && !own_en |=> !out_valid); // R2

  AST_FIRST_TARGET_BYTE: assert property (@(posedge clk) disable iff (rst)
    !busy && br_taken && cfg_bytes != 2'b00
    |=> out_valid && !out_asid && out_data == $past(br_target[BYTE_W-1:0])); // R3

  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_asid)); // R4

  AST_OVF_STEP: assert property (@(posedge clk) disable iff (rst)
    busy && br_taken && cfg_bytes != 2'b00 && ovf_count != '1
    |=> ovf_count == $past(ovf_count) + OVF_W'(1)); // R10

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(busy && br_taken) |=> $stable(ovf_count)); // R10

  AST_NO_ASID_OFF: assert property (@(posedge clk) disable iff (rst)
    !own_en && !out_valid && !br_taken |=> !out_valid); // R8
endmodule

bind trc_emitter trc_emitter_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .OVF_W(OVF_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_bytes(cfg_bytes), .own_en(own_en),
  .br_taken(br_taken), .br_target(br_target), .ev_user(ev_user),
  .ev_asid_load(ev_asid_load), .ev_sync_pc(ev_sync_pc), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .out_asid(out_asid),
  .busy(busy), .ovf_count(ovf_count)
);

// File: tb/trc_emitter_tb_top.sv
`timescale 1ns/1ps
module trc_emitter_tb_top;
  localparam int ADDR_W = 32, BYTE_W = 8, ASID_W = 8, OVF_W = 8;
  localparam int NVEC = 6;
  // {code, target}
  localparam logic [33:0] VEC [NVEC] = '{
    {2'b00, 32'hDEAD_BEEF}, {2'b01, 32'h1234_5678}, {2'b10, 32'hA1B2_C3D4},
    {2'b11, 32'h0F1E_2D3C}, {2'b11, 32'hFFFF_0001}, {2'b01, 32'h8000_00FF}
  };

  logic clk = 0, rst = 1;
  logic [1:0] cfg_bytes = 0;
  logic own_en = 0, br_taken = 0, ev_user = 0, ev_asid_load = 0, ev_sync_pc = 0;
  logic [ADDR_W-1:0] br_target = 0;
  logic [ASID_W-1:0] asid = 0;
  logic out_ready = 1;
  logic out_valid, out_asid, busy;
  logic [BYTE_W-1:0] out_data;
  logic [OVF_W-1:0] ovf_count;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  trc_emitter #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .ASID_W(ASID_W), .OVF_W(OVF_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_bytes(cfg_bytes), .own_en(own_en),
    .br_taken(br_taken), .br_target(br_target), .ev_user(ev_user),
    .ev_asid_load(ev_asid_load), .ev_sync_pc(ev_sync_pc), .asid(asid),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_asid(out_asid), .busy(busy), .ovf_count(ovf_count));

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'b00) ? 0 : int'(c) + 1;
  endfunction

  task automatic branch(input logic [1:0] c, input logic [31:0] t);
    cfg_bytes = c; br_target = t; br_taken = 1; step(); br_taken = 0;
  endtask

  // Expect n target bytes with ready high, then idle.
  task automatic drain_target(input string req, input logic [31:0] t, input int n);
    out_ready = 1;
    for (int i = 0; i < n; i++) begin
      chk(req, {out_asid, out_valid, out_data}, {1'b0, 1'b1, t[8*i +: 8]});
      step();
    end
  endtask

  task automatic asid_event(input int which, input logic [7:0] v);
    asid = v;
    ev_user = (which == 0); ev_asid_load = (which == 1); ev_sync_pc = (which == 2);
    step();
    ev_user = 0; ev_asid_load = 0; ev_sync_pc = 0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1 reset idle", {out_valid, busy, ovf_count}, 0);
    rst = 0; step();
    chk("R1 after reset", {out_valid, busy, ovf_count}, 0);

    // Vector walk: R2, R3
    for (int v = 0; v < NVEC; v++) begin
      branch(VEC[v][33:32], VEC[v][31:0]);
      drain_target(VEC[v][33:32] == 0 ? "R2" : "R3", VEC[v][31:0], nbytes(VEC[v][33:32]));
      chk("R2/R3 record end", out_valid, 0);
    end

    // R4 stall
    out_ready = 0;
    branch(2'b11, 32'hCAFE_F00D);
    for (int i = 0; i < 3; i++) begin
      chk("R4 stall hold", {out_valid, out_asid, out_data}, {1'b1, 1'b0, 8'h0D});
      step();
    end
    drain_target("R4 after stall", 32'hCAFE_F00D, 4);
    chk("R4 end", out_valid, 0);

    // R5 R6 R7 ASID events
    own_en = 1;
    asid_event(0, 8'h5A);
    chk("R5 user entry", {out_valid, out_asid, out_data}, {2'b11, 8'h5A}); step();
    chk("R5 single byte", out_valid, 0);
    asid_event(1, 8'hC3);
    chk("R6 asid load", {out_valid, out_asid, out_data}, {2'b11, 8'hC3}); step();
    chk("R6 single byte", out_valid, 0);
    asid_event(2, 8'h11);
    chk("R7 sync pc", {out_valid, out_asid, out_data}, {2'b11, 8'h11}); step();
    chk("R7 single byte", out_valid, 0);

    // R8 disabled
    own_en = 0;
    for (int w = 0; w < 3; w++) begin
      asid_event(w, 8'h77);
      chk("R8 no asid when off", out_valid, 0);
    end

    // R9 simultaneous
    own_en = 1; asid = 8'h9C; ev_user = 1;
    branch(2'b10, 32'h0055_6677);
    ev_user = 0;
    drain_target("R9 branch first", 32'h0055_6677, 3);
    chk("R9 asid after", {out_valid, out_asid, out_data}, {2'b11, 8'h9C}); step();
    chk("R9 end", out_valid, 0);

    // R10 busy and overflow
    out_ready = 0;
    branch(2'b01, 32'h0000_ABCD);
    chk("R10 busy", busy, 1);
    branch(2'b11, 32'h1111_1111);
    chk("R10 ovf one", ovf_count, 1);
    branch(2'b00, 32'h2222_2222);
    chk("R10 code0 not counted", ovf_count, 1);
    drain_target("R10 kept record", 32'h0000_ABCD, 2);
    chk("R10 dropped silent", {out_valid, busy}, 0);
    out_ready = 0;
    branch(2'b01, 32'h0000_4321);
    cfg_bytes = 2'b10; br_taken = 1;
    for (int i = 0; i < 300; i++) step();
    br_taken = 0;
    chk("R10 saturate", ovf_count, 8'hFF);
    drain_target("R10 after sat", 32'h0000_4321, 2);
    chk("R10 idle", out_valid, 0);

    // R11 holding register
    out_ready = 0;
    asid_event(0, 8'hA0);
    asid_event(1, 8'hB0);
    chk("R11 held keeps first", out_data, 8'hA0);
    out_ready = 1; step();
    chk("R11 second dropped", out_valid, 0);
    out_ready = 0;
    asid_event(2, 8'hC0);
    out_ready = 1; asid = 8'hD0; ev_user = 1; step(); ev_user = 0;
    chk("R11 load on drain", {out_valid, out_asid, out_data}, {2'b11, 8'hD0});
    step();
    chk("R11 end", out_valid, 0);

    // R1 reset clears counter
    rst = 1; step();
    chk("R1 reset clears", {out_valid, ovf_count}, 0);
    rst = 0; step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule